// File: doc/BRIEF.md
# Video Sync Input Conditioner

This block sits between the horizontal and vertical sync pins of a display controller and the rest of the timing logic. Everything runs from one oscillator clock. Each sync input passes through a synchronizer and a short agreement filter, so a pulse that is seen at only one clock edge never reaches the rest of the block. For every filtered channel the block counts the clocks between successive rising edges, works out which level the signal spends most of its time at, and decides whether the signal is there at all.

Downstream logic receives sync in a fixed active-high form. The block XORs each input with its own detected polarity flag to get that form. A control bit per output can then invert it again. A separator watches the normalized horizontal input for over-long active phases, which mark the vertical interval of a composite sync. A select input chooses whether the vertical output comes from that separator or from the dedicated vertical pin. While the vertical interval is active, an insertion stage can replace the horizontal output with locally generated pulses at the measured line period. A gap guard keeps the vertical blanking output from following vertical edges that arrive too close together.

Top module: `sync_proc`

## Requirements
- R1: After reset, every presence flag, polarity flag and period count is 0, and both outputs are 0 when their XOR control bits are 0.
- R2: A level on either sync input is taken into the filtered signal only after it has been sampled at two consecutive clock edges. A pulse caught at a single edge has no effect on presence, period or polarity.
- R3: The period count of a channel equals the number of clocks between two consecutive rising edges of its filtered signal, and it is updated at each rising edge. Horizontal counts are HCNT_W bits wide and vertical counts are VCNT_W bits wide.
- R4: A period longer than the counter can hold is reported as the all-ones value of that counter.
- R5: The polarity flag of a channel is 1 exactly when, over the last measured period, the filtered signal spent more clocks at 1 than at 0. The flag is updated only at a rising edge.
- R6: The presence flag is set at the second filtered rising edge that arrives without a timeout in between. It is cleared once 2^HTO_W clocks (horizontal) or 2^VTO_W clocks (vertical and separated vertical) pass without a rising edge.
- R7: hsync_o equals the normalized horizontal sync (filtered input XOR horizontal polarity flag) XOR hxor_i. vblank_o equals the guarded vertical signal XOR vxor_i.
- R8: The separator asserts the separated vertical signal while a normalized horizontal active phase has lasted at least the threshold. The threshold is sep_thr_i, or half the horizontal period count when sep_thr_i is 0. The separated signal has its own presence flag and period count.
- R9: vsel_i = 1 takes the vertical signal from the separator; vsel_i = 0 takes it from vsync_i after normalization.
- R10: While ins_en_i = 1 and the selected vertical signal is active, the horizontal output carries INS_PW-clock pulses that repeat every measured horizontal period. Otherwise it follows the normalized input.
- R11: A rising edge of the selected vertical signal starts a blanking pulse only if at least VGAP_MIN clocks have passed since the previous accepted one. The first edge after reset is always accepted, and blanking ends when the vertical signal goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal or composite sync pin |
| vsync_i | input | 1 | Vertical sync pin |
| vsel_i | input | 1 | Vertical source: 0 pin, 1 separator |
| ins_en_i | input | 1 | Enable horizontal pulse insertion |
| hxor_i | input | 1 | Horizontal output inversion |
| vxor_i | input | 1 | Vertical blanking output inversion |
| sep_thr_i | input | HCNT_W | Separator threshold in clocks, 0 selects half period |
| hsync_o | output | 1 | Conditioned horizontal sync |
| vblank_o | output | 1 | Guarded vertical blanking |
| h_present_o | output | 1 | Horizontal input present |
| v_present_o | output | 1 | Vertical pin present |
| cv_present_o | output | 1 | Separated vertical present |
| h_pol_neg_o | output | 1 | Horizontal input mostly high |
| v_pol_neg_o | output | 1 | Vertical pin mostly high |
| cv_pol_neg_o | output | 1 | Separated vertical mostly high |
| h_period_o | output | HCNT_W | Horizontal period in clocks |
| v_period_o | output | VCNT_W | Vertical period in clocks |
| cv_period_o | output | VCNT_W | Separated vertical period in clocks |

## Verification
The bench builds the block with HCNT_W = 10, VCNT_W = 12, HTO_W = 9, VTO_W = 11, INS_PW = 4 and VGAP_MIN = 64. With these values a 1100-clock line drives the horizontal counter into saturation. Loss of horizontal presence shows up about 512 clocks after the input stops. A 20-clock vertical burst shows the gap guard thinning accepted blanking pulses to one every 80 clocks, all within a few thousand cycles.

// File: rtl/sync_proc_pkg.sv
package sync_proc_pkg;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_SEP = 1'b1
    } vsrc_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic lvl;
        logic rise;
    } filt_t;

endpackage

// File: rtl/sync_proc_filter.sv
module sync_proc_filter
    import sync_proc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic lvl_o,
    output logic rise_o
);

    filt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_i;
        st_d.s2   = st_q.s1;
        st_d.s3   = st_q.s2;
        st_d.rise = 1'b0;
        // accept a new level only after two matching synchronized samples
        if ((st_q.s2 == st_q.s3) && (st_q.s2 != st_q.lvl)) begin
            st_d.lvl  = st_q.s2;
            st_d.rise = st_q.s2;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o  = st_q.lvl;
    assign rise_o = st_q.rise;

endmodule

// File: rtl/sync_proc_chan.sv
module sync_proc_chan #(
    parameter int CNT_W = 14,
    parameter int TO_W  = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lvl_i,
    input  logic             rise_i,
    output logic             pres_o,
    output logic             neg_o,
    output logic [CNT_W-1:0] per_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [TO_W-1:0]  TO_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] per;
        logic             neg;
        logic [TO_W-1:0]  tmo;
        logic             armed;
        logic             pres;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.per   = st_q.cnt;
            st_d.neg   = (st_q.hi > st_q.lo);
            st_d.cnt   = CNT_ONE;
            st_d.hi    = CNT_ONE;
            st_d.lo    = '0;
            st_d.tmo   = '0;
            st_d.armed = 1'b1;
            if (st_q.armed) st_d.pres = 1'b1;
        end else begin
            if (st_q.cnt != CNT_MAX)          st_d.cnt = st_q.cnt + 1'b1;
            if (lvl_i && st_q.hi != CNT_MAX)  st_d.hi  = st_q.hi + 1'b1;
            if (!lvl_i && st_q.lo != CNT_MAX) st_d.lo  = st_q.lo + 1'b1;
            if (st_q.tmo == TO_MAX) begin
                st_d.armed = 1'b0;
                st_d.pres  = 1'b0;
            end else begin
                st_d.tmo = st_q.tmo + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pres_o = st_q.pres;
    assign neg_o  = st_q.neg;
    assign per_o  = st_q.per;

endmodule

// File: rtl/sync_proc_sep.sv
module sync_proc_sep #(
    parameter int CNT_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             act_i,
    input  logic [CNT_W-1:0] hper_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             lvl_o,
    output logic             rise_o
);

    localparam logic [CNT_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             vs;
        logic             rise;
    } sep_t;

    sep_t             st_d, st_q;
    logic [CNT_W-1:0] thr;

    always_comb begin
        thr = (thr_i != '0) ? thr_i : (hper_i >> 1);
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (!act_i) begin
            st_d.run = '0;
            st_d.vs  = 1'b0;
        end else begin
            if (st_q.run != RUN_MAX) st_d.run = st_q.run + 1'b1;
            if (!st_q.vs && (st_q.run >= thr)) begin
                st_d.vs   = 1'b1;
                st_d.rise = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o  = st_q.vs;
    assign rise_o = st_q.rise;

endmodule

// File: rtl/sync_proc.sv
module sync_proc
    import sync_proc_pkg::*;
#(
    parameter int HCNT_W   = 14,
    parameter int VCNT_W   = 20,
    parameter int HTO_W    = 16,
    parameter int VTO_W    = 20,
    parameter int INS_PW   = 8,
    parameter int VGAP_MIN = 256
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              vsel_i,
    input  logic              ins_en_i,
    input  logic              hxor_i,
    input  logic              vxor_i,
    input  logic [HCNT_W-1:0] sep_thr_i,
    output logic              hsync_o,
    output logic              vblank_o,
    output logic              h_present_o,
    output logic              v_present_o,
    output logic              cv_present_o,
    output logic              h_pol_neg_o,
    output logic              v_pol_neg_o,
    output logic              cv_pol_neg_o,
    output logic [HCNT_W-1:0] h_period_o,
    output logic [VCNT_W-1:0] v_period_o,
    output logic [VCNT_W-1:0] cv_period_o
);

    localparam int                GAP_W  = $clog2(VGAP_MIN + 1);
    localparam logic [GAP_W-1:0]  GAP_LIM = GAP_W'(VGAP_MIN);
    localparam logic [HCNT_W-1:0] PW_LIM  = HCNT_W'(INS_PW);
    localparam logic [HCNT_W:0]   PH_ONE  = (HCNT_W+1)'(1);

    typedef struct packed {
        logic [HCNT_W-1:0] ph;
        logic              hact;
        logic              vprev;
        logic [GAP_W-1:0]  gap;
        logic              vbl;
        logic              hout;
    } top_t;

    top_t              st_d, st_q;
    logic              h_lvl, h_rise, v_lvl, v_rise, cv_lvl, cv_rise;
    logic              h_act, v_pin_act, v_sel_act, insert, h_align, vbl;
    logic [HCNT_W-1:0] h_per;

    sync_proc_filter u_hflt (
        .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(hsync_i),
        .lvl_o (h_lvl), .rise_o(h_rise)
    );

    sync_proc_filter u_vflt (
        .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(vsync_i),
        .lvl_o (v_lvl), .rise_o(v_rise)
    );

    sync_proc_chan #(.CNT_W(HCNT_W), .TO_W(HTO_W)) u_hchan (
        .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(h_lvl), .rise_i(h_rise),
        .pres_o(h_present_o), .neg_o(h_pol_neg_o), .per_o(h_per)
    );

    sync_proc_chan #(.CNT_W(VCNT_W), .TO_W(VTO_W)) u_vchan (
        .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(v_lvl), .rise_i(v_rise),
        .pres_o(v_present_o), .neg_o(v_pol_neg_o), .per_o(v_period_o)
    );

    assign h_act     = h_lvl ^ h_pol_neg_o;
    assign v_pin_act = v_lvl ^ v_pol_neg_o;

    sync_proc_sep #(.CNT_W(HCNT_W)) u_sep (
        .clk_i (clk_i), .rst_ni(rst_ni), .act_i(h_act),
        .hper_i(h_per), .thr_i(sep_thr_i),
        .lvl_o (cv_lvl), .rise_o(cv_rise)
    );

    sync_proc_chan #(.CNT_W(VCNT_W), .TO_W(VTO_W)) u_cvchan (
        .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(cv_lvl), .rise_i(cv_rise),
        .pres_o(cv_present_o), .neg_o(cv_pol_neg_o), .per_o(cv_period_o)
    );

    assign h_period_o = h_per;
    assign v_sel_act  = (vsrc_e'(vsel_i) == SRC_SEP) ? cv_lvl : v_pin_act;

    always_comb begin
        st_d    = st_q;
        insert  = ins_en_i & v_sel_act;
        h_align = h_act & ~st_q.hact;

        // local line phase: realigned by real lines, free-running while inserting
        st_d.hact = h_act;
        if (!insert && h_align) begin
            st_d.ph = '0;
        end else if (({1'b0, st_q.ph} + PH_ONE) >= {1'b0, h_per}) begin
            st_d.ph = '0;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
        st_d.hout = insert ? (st_q.ph < PW_LIM) : h_act;

        // vertical blanking with minimum spacing between accepted starts
        st_d.vprev = v_sel_act;
        if (st_q.gap < GAP_LIM) st_d.gap = st_q.gap + 1'b1;
        if (v_sel_act && !st_q.vprev && (st_q.gap >= GAP_LIM)) begin
            st_d.vbl = 1'b1;
            st_d.gap = '0;
        end
        if (!v_sel_act) st_d.vbl = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.gap <= GAP_LIM;
        end else begin
            st_q <= st_d;
        end
    end

    assign vbl      = st_q.vbl;
    assign hsync_o  = st_q.hout ^ hxor_i;
    assign vblank_o = vbl ^ vxor_i;

endmodule

// File: rtl/sync_proc_chk.sv
module sync_proc_chk #(
    parameter int HCNT_W   = 14,
    parameter int VGAP_MIN = 256
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              hsync_i,
    input logic              h_lvl,
    input logic              h_rise,
    input logic              h_act,
    input logic              cv_lvl,
    input logic              vbl,
    input logic              h_present_o,
    input logic              h_pol_neg_o,
    input logic [HCNT_W-1:0] h_period_o
);

    localparam int               CW  = $clog2(VGAP_MIN + 1);
    localparam logic [CW-1:0]    LIM = CW'(VGAP_MIN);

    logic [CW-1:0] since_q;
    logic          vbl_p;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q <= LIM;
            vbl_p   <= 1'b0;
        end else begin
            vbl_p <= vbl;
            if (vbl && !vbl_p)   since_q <= '0;
            else if (since_q < LIM) since_q <= since_q + 1'b1;
        end
    end

    AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(h_lvl) |-> (($past(hsync_i, 3) == h_lvl) && ($past(hsync_i, 4) == h_lvl))); // R2

    AST_PER_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(h_period_o) |-> $past(h_rise)); // R3

    AST_POL_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(h_pol_neg_o) |-> $past(h_rise)); // R5

    AST_PRES_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(h_present_o) |-> $past(h_rise)); // R6

    AST_SEP_IN_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cv_lvl) |-> $past(h_act)); // R8

    AST_VBL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vbl) |-> (since_q >= LIM)); // R11

endmodule

bind sync_proc sync_proc_chk #(.HCNT_W(HCNT_W), .VGAP_MIN(VGAP_MIN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsync_i    (hsync_i),
    .h_lvl      (h_lvl),
    .h_rise     (h_rise),
    .h_act      (h_act),
    .cv_lvl     (cv_lvl),
    .vbl        (vbl),
    .h_present_o(h_present_o),
    .h_pol_neg_o(h_pol_neg_o),
    .h_period_o (h_period_o)
);

// File: tb/sync_proc_test.sv
module sync_proc_test;

    localparam int CLK_PERIOD = 10;
    localparam int HCNT_W = 10;
    localparam int VCNT_W = 12;
    localparam int NVEC   = 6;
    // hper, hhi, inverted, expected period, expected polarity flag
    localparam int VEC [NVEC][5] = '{
        '{  40,   4, 0,   40, 0},
        '{  40,   4, 1,   40, 1},
        '{ 100,  70, 0,  100, 1},
        '{ 257,  30, 0,  257, 0},
        '{  63,  31, 1,   63, 1},
        '{1100, 100, 0, 1023, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_i = 1'b0, vsync_i = 1'b0;
    logic vsel_i = 1'b0, ins_en_i = 1'b0, hxor_i = 1'b0, vxor_i = 1'b0;
    logic [HCNT_W-1:0] sep_thr_i = '0;
    logic hsync_o, vblank_o, h_present_o, v_present_o, cv_present_o;
    logic h_pol_neg_o, v_pol_neg_o, cv_pol_neg_o;
    logic [HCNT_W-1:0] h_period_o;
    logic [VCNT_W-1:0] v_period_o, cv_period_o;

    int n_chk = 0, n_fail = 0;
    int hper = 40, hhi = 4, vper = 1000, vhi = 30, hph = 0, vph = 0;
    bit h_run = 0, v_run = 0, h_inv = 0, v_inv = 0, cmode = 0, v_pin = 0, h_gate = 0;

    sync_proc #(
        .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .HTO_W(9), .VTO_W(11),
        .INS_PW(4), .VGAP_MIN(64)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .vsel_i(vsel_i), .ins_en_i(ins_en_i), .hxor_i(hxor_i), .vxor_i(vxor_i),
        .sep_thr_i(sep_thr_i), .hsync_o(hsync_o), .vblank_o(vblank_o),
        .h_present_o(h_present_o), .v_present_o(v_present_o),
        .cv_present_o(cv_present_o), .h_pol_neg_o(h_pol_neg_o),
        .v_pol_neg_o(v_pol_neg_o), .cv_pol_neg_o(cv_pol_neg_o),
        .h_period_o(h_period_o), .v_period_o(v_period_o), .cv_period_o(cv_period_o)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // waveform generator, updates on the falling edge
    initial begin
        forever begin
            bit vg, hg;
            @(negedge clk);
            hph = (hph + 1 >= hper) ? 0 : hph + 1;
            vph = (vph + 1 >= vper) ? 0 : vph + 1;
            vg = v_run && (vph < vhi);
            hg = h_run && (hph < hhi) && !(h_gate && vg);
            hsync_i = (hg || (cmode && vg)) ^ h_inv;
            vsync_i = (v_pin && vg) ^ v_inv;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        h_run = 0; v_run = 0; h_inv = 0; v_inv = 0; cmode = 0; v_pin = 0; h_gate = 0;
        vsel_i = 0; ins_en_i = 0; hxor_i = 0; vxor_i = 0; sep_thr_i = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(1);
    endtask

    task automatic count_high_h(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk); if (hsync_o) c++; end
    endtask

    task automatic count_high_v(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk); if (vblank_o) c++; end
    endtask

    initial begin
        int c;
        do_reset();
        // R1: reset state
        check(h_present_o == 0 && v_present_o == 0 && cv_present_o == 0, "R1 presence", 
              int'(h_present_o) + int'(v_present_o) + int'(cv_present_o), 0);
        check(h_pol_neg_o == 0 && v_pol_neg_o == 0, "R1 polarity",
              int'(h_pol_neg_o) + int'(v_pol_neg_o), 0);
        check(h_period_o == 0 && v_period_o == 0 && cv_period_o == 0, "R1 periods",
              int'(h_period_o) + int'(v_period_o), 0);
        check(hsync_o == 0 && vblank_o == 0, "R1 outputs", int'(hsync_o) + int'(vblank_o), 0);

        // R3 / R4 / R5: vector table
        h_run = 1;
        for (int i = 0; i < NVEC; i++) begin
            hper = VEC[i][0]; hhi = VEC[i][1]; h_inv = VEC[i][2][0];
            wait_clk(hper * 6);
            check(int'(h_period_o) == VEC[i][3], (i == NVEC - 1) ? "R4 saturation" : "R3 period",
                  int'(h_period_o), VEC[i][3]);
            check(int'(h_pol_neg_o) == VEC[i][4], "R5 polarity", int'(h_pol_neg_o), VEC[i][4]);
        end

        // R2: single-sample pulses rejected, two-sample pulses accepted
        do_reset();
        v_pin = 1; v_run = 1; vper = 50; vhi = 1;
        wait_clk(1500);
        check(v_present_o == 0, "R2 glitch presence", int'(v_present_o), 0);
        check(v_period_o == 0, "R2 glitch period", int'(v_period_o), 0);
        vhi = 2;
        wait_clk(300);
        check(v_present_o == 1, "R2 two-sample pulse", int'(v_present_o), 1);
        check(int'(v_period_o) == 50, "R3 vertical period", int'(v_period_o), 50);

        // R6: presence set and timeout
        do_reset();
        hper = 40; hhi = 4; h_run = 1;
        wait_clk(200);
        check(h_present_o == 1, "R6 set", int'(h_present_o), 1);
        h_run = 0;
        wait_clk(400);
        check(h_present_o == 1, "R6 inside window", int'(h_present_o), 1);
        wait_clk(250);
        check(h_present_o == 0, "R6 timeout", int'(h_present_o), 0);

        // R7: normalization and output inversion
        do_reset();
        hper = 40; hhi = 10; h_inv = 1; h_run = 1;
        wait_clk(200);
        count_high_h(400, c);
        check(c >= 98 && c <= 102, "R7 normalized", c, 100);
        hxor_i = 1; wait_clk(1);
        count_high_h(400, c);
        check(c >= 298 && c <= 302, "R7 inverted", c, 300);
        vxor_i = 1; wait_clk(1);
        check(vblank_o == 1, "R7 vertical inversion", int'(vblank_o), 1);

        // R8 / R9: composite separation
        do_reset();
        hper = 40; hhi = 4; h_run = 1; cmode = 1; v_run = 1; vper = 1000; vhi = 150;
        vsel_i = 1;
        wait_clk(3500);
        check(cv_present_o == 1, "R8 separated presence", int'(cv_present_o), 1);
        count_high_v(1000, c);
        check(c >= 100 && c <= 150, "R9 separator selected", c, 130);
        sep_thr_i = 400;
        wait_clk(1000);
        count_high_v(1000, c);
        check(c == 0, "R8 threshold above broad pulse", c, 0);
        sep_thr_i = '0; vsel_i = 0;
        wait_clk(1000);
        count_high_v(1000, c);
        check(c == 0, "R9 pin selected idle", c, 0);

        // R10: pulse insertion during vertical interval
        do_reset();
        hper = 40; hhi = 4; h_run = 1; h_gate = 1;
        v_pin = 1; v_run = 1; vper = 1000; vhi = 300; ins_en_i = 1;
        wait_clk(2500);
        begin
            int r = 0; bit p = hsync_o;
            repeat (1000) begin
                @(negedge clk);
                if (vblank_o && hsync_o && !p) r++;
                p = hsync_o;
            end
            check(r >= 5, "R10 inserted pulses", r, 7);
        end
        ins_en_i = 0;
        wait_clk(1000);
        begin
            int r = 0; bit p = hsync_o;
            repeat (1000) begin
                @(negedge clk);
                if (vblank_o && hsync_o && !p) r++;
                p = hsync_o;
            end
            check(r <= 1, "R10 insertion off", r, 0);
        end

        // R11: blanking gap guard under fast vertical edges
        do_reset();
        v_pin = 1; v_run = 1; vper = 20; vhi = 5;
        wait_clk(200);
        begin
            int r = 0; bit p = vblank_o;
            repeat (1600) begin
                @(negedge clk);
                if (vblank_o && !p) r++;
                p = vblank_o;
            end
            check(r >= 18 && r <= 22, "R11 guarded starts", r, 20);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule